// File: doc/BRIEF.md
# Camera Configuration Serial Writer

This block is the bus master on a two-wire control link to an image sensor. The sensor is always a slave. Each write sends three bytes: the sensor's bus identity, the index of the register to change and the new value. A host-side command path hands in a register index and a value with a one-cycle strobe. The block then shifts the write out on a serial clock line and a serial data line, and it signals when the write has finished.

Both lines are driven in open-drain style. For each line a pull-low flag means drive the line low when set, and release it to the external pull-up when clear. The bit rate comes from a quarter-period clock-enable divider. Every bit slot is four quarters long, so data is set up and held well clear of the clock edges.

After reset the block works through a built-in list of register writes on its own. Only after that does it report itself free for host requests. The acknowledge bit that follows each byte is released and never read, and the block does not support register reads, clock stretching or multi-master arbitration.

Top module: `sccb_cfg_writer`

## Requirements
- R1: While `rst_n` is low, and for the two clock edges that follow its release, `busy` is 1, `done` is 0 and both pull-low flags are 0. At any time when `busy` is 0, both pull-low flags are 0.
- R2: After reset the block writes the BOOT_LEN entries of BOOT_LIST in order, lowest index first. Entry i occupies bits [16i+15:16i], with the register index in its upper byte and the value in its lower byte. The first write begins in the cycle after the third rising clock edge following reset release. The writes run back to back, and `busy` stays 1 until the `done` of the last entry.
- R3: A write consists of a start slot, 27 bit slots and a stop slot. In the start slot the data line falls while the clock is high. The bit slots carry DEV_ID, then the register index, then the value, each byte followed by one extra bit. In the stop slot the data line rises while the clock is high.
- R4: Bytes go out most significant bit first. In a bit slot the clock is low in the first and fourth quarters and high in the second and third. The data line changes only while the clock is low, except inside start and stop slots.
- R5: During the ninth bit slot of each byte the data line is released (`sda_low` = 0) and its level is never used.
- R6: Every slot lasts four quarters of QTR_CYC clock cycles, so consecutive clock rises within a write are 4*QTR_CYC cycles apart.
- R7: When `req_valid` is 1 and `busy` is 0 at a rising edge, `req_addr` and `req_data` are captured. `busy` is then 1 and the start slot begins in the next cycle.
- R8: A request presented while `busy` is 1 is ignored. No write for it ever appears on the lines.
- R9: `done` is a one-cycle pulse in the cycle after the last quarter of a stop slot. In that cycle `busy` is 0 unless list entries remain.
- R10: A request presented in the `done` cycle is accepted, and its start slot follows without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | 8 | Register index for the requested write |
| req_data | input | 8 | Value for the requested write |
| busy | output | 1 | A write or the power-on list is in progress |
| done | output | 1 | One-cycle pulse when a write's stop slot ends |
| scl_low | output | 1 | Pull serial clock line low when 1, release when 0 |
| sda_low | output | 1 | Pull serial data line low when 1, release when 0 |

## Verification
A wrong slot, quarter or bit counter shows up as a level mismatch on `scl_low` or `sda_low` within one quarter period. A corrupted captured frame shows up when the first affected bit is shifted out, and at the latest when the bench decodes the complete write at its stop condition. A lost or duplicated power-on entry, or a request that is wrongly accepted, changes the cycle in which `busy` and `done` move, so the next per-cycle comparison catches it. Because the bench compares every output on every clock against a behavioural model, a divider that is off by one cycle is caught at the end of the first quarter.

// File: rtl/sccb_pkg.sv
package sccb_pkg;
  // Slot kinds on the serial link
  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_START = 2'd1,
    SL_BIT   = 2'd2,
    SL_STOP  = 2'd3
  } slot_e;

  // One register write as seen from the request side
  typedef struct packed {
    logic [7:0] reg_addr;
    logic [7:0] reg_data;
  } wr_req_t;

  localparam int unsigned BITS_PER_BYTE   = 9;  // eight data bits plus released bit
  localparam int unsigned BYTES_PER_WRITE = 3;  // identity, index, value
  localparam int unsigned FRAME_W         = 8 * BYTES_PER_WRITE;
endpackage

// File: rtl/sccb_qtr_tick.sv
module sccb_qtr_tick #(
  parameter int unsigned QTR_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/sccb_boot_seq.sv
module sccb_boot_seq
  import sccb_pkg::*;
#(
  parameter int unsigned BOOT_LEN = 3,
  parameter logic [BOOT_LEN*16-1:0] BOOT_LIST = '0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  output logic    pending,
  output wr_req_t entry
);
  localparam int unsigned IW = $clog2(BOOT_LEN + 1);
  localparam logic [IW-1:0] END_IDX = IW'(BOOT_LEN);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;
  wr_req_t       tbl [BOOT_LEN];

  for (genvar g = 0; g < BOOT_LEN; g++) begin : g_tbl
    assign tbl[g] = BOOT_LIST[16*g +: 16];
  end

  assign pending = (idx_q != END_IDX);

  always_comb begin
    entry = '0;
    for (int i = 0; i < BOOT_LEN; i++) begin
      if (idx_q == IW'(i)) begin
        entry = tbl[i];
      end
    end
  end

  always_comb begin
    idx_d = idx_q;
    if (take && pending) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/sccb_write_engine.sv
module sccb_write_engine
  import sccb_pkg::*;
#(
  parameter int unsigned QTR_CYC = 250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         id_byte,
  input  wr_req_t            req,
  output logic               busy,
  output logic               done,
  output logic               scl_low,
  output logic               sda_low,
  output slot_e              slot_o,
  output logic [3:0]         bit_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [3:0] LAST_BIT  = 4'(BITS_PER_BYTE - 1);
  localparam logic [1:0] LAST_BYTE = 2'(BYTES_PER_WRITE - 1);

  slot_e              slot_q, slot_d;
  logic [1:0]         qtr_q, qtr_d;
  logic [3:0]         bit_q, bit_d;
  logic [1:0]         byte_q, byte_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               done_q, done_d;
  logic               tick;
  logic [7:0]         cur_byte;
  logic               bit_val;
  logic               scl_hi;
  logic               sda_hi;

  sccb_qtr_tick #(
    .QTR_CYC(QTR_CYC)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (slot_q != SL_IDLE),
    .tick (tick)
  );

  // next-state logic
  always_comb begin
    slot_d  = slot_q;
    qtr_d   = qtr_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    frame_d = frame_q;
    done_d  = 1'b0;
    if (slot_q == SL_IDLE) begin
      if (start) begin
        slot_d  = SL_START;
        qtr_d   = 2'd0;
        bit_d   = 4'd0;
        byte_d  = 2'd0;
        frame_d = {id_byte, req.reg_addr, req.reg_data};
      end
    end else if (tick) begin
      qtr_d = qtr_q + 2'd1;
      if (qtr_q == 2'd3) begin
        case (slot_q)
          SL_START: slot_d = SL_BIT;
          SL_BIT: begin
            if (bit_q == LAST_BIT) begin
              bit_d = 4'd0;
              if (byte_q == LAST_BYTE) begin
                slot_d = SL_STOP;
              end else begin
                byte_d = byte_q + 2'd1;
              end
            end else begin
              bit_d = bit_q + 4'd1;
            end
          end
          SL_STOP: begin
            slot_d = SL_IDLE;
            done_d = 1'b1;
          end
          default: slot_d = SL_IDLE;
        endcase
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SL_IDLE;
      qtr_q   <= 2'd0;
      bit_q   <= 4'd0;
      byte_q  <= 2'd0;
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      qtr_q   <= qtr_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      frame_q <= frame_d;
      done_q  <= done_d;
    end
  end

  // byte currently on the wire
  always_comb begin
    case (byte_q)
      2'd0:    cur_byte = frame_q[23:16];
      2'd1:    cur_byte = frame_q[15:8];
      default: cur_byte = frame_q[7:0];
    endcase
  end

  assign bit_val = cur_byte[3'd7 - bit_q[2:0]];

  // line levels per slot and quarter
  always_comb begin
    scl_hi = 1'b1;
    sda_hi = 1'b1;
    case (slot_q)
      SL_START: begin
        scl_hi = (qtr_q != 2'd3);
        sda_hi = (qtr_q < 2'd2);
      end
      SL_BIT: begin
        scl_hi = (qtr_q == 2'd1) || (qtr_q == 2'd2);
        sda_hi = (bit_q == LAST_BIT) ? 1'b1 : bit_val;
      end
      SL_STOP: begin
        scl_hi = (qtr_q != 2'd0);
        sda_hi = (qtr_q >= 2'd2);
      end
      default: begin
        scl_hi = 1'b1;
        sda_hi = 1'b1;
      end
    endcase
  end

  assign scl_low = !scl_hi;
  assign sda_low = !sda_hi;
  assign busy    = (slot_q != SL_IDLE);
  assign done    = done_q;
  assign slot_o  = slot_q;
  assign bit_o   = bit_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/sccb_cfg_writer.sv
module sccb_cfg_writer
  import sccb_pkg::*;
#(
  parameter int unsigned QTR_CYC = 250,
  parameter logic [7:0]  DEV_ID  = 8'h42,
  parameter int unsigned BOOT_LEN = 3,
  parameter logic [BOOT_LEN*16-1:0] BOOT_LIST = 48'h1480_1100_1280
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_data,
  output logic       busy,
  output logic       done,
  output logic       scl_low,
  output logic       sda_low
);
  logic [1:0]         rsync_q;
  logic               rst_core_n;
  logic               boot_pending;
  wr_req_t            boot_entry;
  wr_req_t            host_req;
  wr_req_t            eng_req;
  logic               eng_busy;
  logic               eng_start;
  logic               boot_take;
  slot_e              eng_slot;
  logic [3:0]         eng_bit;
  logic [FRAME_W-1:0] eng_frame;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  assign host_req.reg_addr = req_addr;
  assign host_req.reg_data = req_data;

  // power-on list has priority; host only sees a free block once it is empty
  assign boot_take = !eng_busy && boot_pending;
  assign eng_start = !eng_busy && (boot_pending || req_valid);
  assign eng_req   = boot_pending ? boot_entry : host_req;
  assign busy      = eng_busy || boot_pending;

  sccb_boot_seq #(
    .BOOT_LEN (BOOT_LEN),
    .BOOT_LIST(BOOT_LIST)
  ) u_boot (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .take   (boot_take),
    .pending(boot_pending),
    .entry  (boot_entry)
  );

  sccb_write_engine #(
    .QTR_CYC(QTR_CYC)
  ) u_eng (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start  (eng_start),
    .id_byte(DEV_ID),
    .req    (eng_req),
    .busy   (eng_busy),
    .done   (done),
    .scl_low(scl_low),
    .sda_low(sda_low),
    .slot_o (eng_slot),
    .bit_o  (eng_bit),
    .frame_o(eng_frame)
  );
endmodule

// File: rtl/sccb_cfg_writer_sva.sv
module sccb_cfg_writer_sva
  import sccb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               busy,
  input logic               done,
  input logic               scl_low,
  input logic               sda_low,
  input slot_e              slot,
  input logic [3:0]         bit_idx,
  input logic [FRAME_W-1:0] frame
);
  // R1: a free block leaves both lines to the pull-ups
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  // R4: data moves under a high clock only inside start and stop slots
  p_data_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
      |-> (slot == SL_START || slot == SL_STOP));

  // R5: the ninth bit of each byte is released
  p_ack_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SL_BIT && bit_idx == 4'd8) |-> !sda_low);

  // R7: an accepted request opens a start slot in the next cycle
  p_accept_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (slot == SL_START));

  // R8: the captured frame cannot change while a write is running
  p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != SL_IDLE && $past(slot) != SL_IDLE) |-> $stable(frame));

  // R9: done is a single-cycle pulse following a stop slot
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(slot) == SL_STOP && slot != SL_STOP));
endmodule

bind sccb_cfg_writer sccb_cfg_writer_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .scl_low  (scl_low),
  .sda_low  (sda_low),
  .slot     (eng_slot),
  .bit_idx  (eng_bit),
  .frame    (eng_frame)
);

// File: tb/sccb_cfg_writer_tb.sv
module sccb_cfg_writer_tb;
  localparam int unsigned QTR   = 3;
  localparam logic [7:0]  DEV   = 8'h42;
  localparam int unsigned NBOOT = 2;
  localparam logic [NBOOT*16-1:0] LIST = 32'h3C5A_81F0;
  localparam int TOT = 116 * QTR;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_addr;
  logic [7:0] req_data;
  logic       busy;
  logic       done;
  logic       scl_low;
  logic       sda_low;

  always #4 clk = ~clk;

  sccb_cfg_writer #(
    .QTR_CYC  (QTR),
    .DEV_ID   (DEV),
    .BOOT_LEN (NBOOT),
    .BOOT_LIST(LIST)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_data (req_data),
    .busy     (busy),
    .done     (done),
    .scl_low  (scl_low),
    .sda_low  (sda_low)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  int  cyc = 0;
  int  n_done = 0;
  bit  armed = 1'b0;
  bit  finished = 1'b0;

  // behavioural reference state
  int          sync_cnt = 0;
  bit          m_act = 1'b0;
  int          m_pos = 0;
  int          m_boot = NBOOT;
  bit          m_done = 1'b0;
  logic [23:0] m_frame = '0;
  logic [23:0] frames_q[$];

  // line decoder state
  logic        p_scl = 1'b0;
  logic        p_sda = 1'b0;
  bit          in_xfer = 1'b0;
  int          bcnt = 0;
  int          last_rise = 0;
  logic [23:0] acc = '0;
  logic [23:0] want;
  logic        e_busy, e_done, e_scl, e_sda;
  string       tg;

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b exp %b at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  task automatic chk_int(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h exp %0h at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic void line_ref(input int p, input logic [23:0] f,
                                   output logic s_lo, output logic d_lo, output string tag);
    int q, slot, qq, j;
    logic s_hi, d_hi;
    q = p / QTR;
    slot = q / 4;
    qq = q % 4;
    if (slot == 0) begin
      s_hi = (qq != 3); d_hi = (qq < 2); tag = "R3";
    end else if (slot == 28) begin
      s_hi = (qq != 0); d_hi = (qq >= 2); tag = "R3";
    end else begin
      j = slot - 1;
      s_hi = (qq == 1) || (qq == 2);
      if (j % 9 == 8) begin
        d_hi = 1'b1; tag = "R5";
      end else begin
        d_hi = f[23 - 8*(j/9) - (j%9)]; tag = "R4";
      end
    end
    s_lo = !s_hi;
    d_lo = !d_hi;
  endfunction

  // reference model steps on the same edge as the design
  always @(posedge clk) begin
    cyc++;
    armed = 1'b1;
    if (!rst_n) begin
      sync_cnt = 0; m_act = 1'b0; m_pos = 0; m_boot = NBOOT; m_done = 1'b0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else begin
      m_done = 1'b0;
      if (m_act) begin
        m_pos++;
        if (m_pos == TOT) begin
          m_act = 1'b0; m_done = 1'b1;
        end
      end else if (m_boot > 0) begin
        m_frame = {DEV, LIST[16*(NBOOT-m_boot) +: 16]};
        frames_q.push_back(m_frame);
        m_boot--; m_act = 1'b1; m_pos = 0;
      end else if (req_valid) begin
        m_frame = {DEV, req_addr, req_data};
        frames_q.push_back(m_frame);
        m_act = 1'b1; m_pos = 0;
      end
    end
  end

  // compare every cycle and decode the wire independently
  always @(negedge clk) begin
    if (armed && !finished) begin
      e_busy = m_act || (m_boot > 0);
      e_done = m_done;
      if (m_act) begin
        line_ref(m_pos, m_frame, e_scl, e_sda, tg);
      end else begin
        e_scl = 1'b0; e_sda = 1'b0;
        tg = (sync_cnt < 2) ? "R1" : "R8";
      end
      chk(tg, "scl_low", scl_low, e_scl);
      chk(tg, "sda_low", sda_low, e_sda);
      chk("R7", "busy", busy, e_busy);
      chk("R9", "done", done, e_done);
      if (done) n_done++;

      if (!p_scl && !scl_low && !p_sda && sda_low) begin
        in_xfer = 1'b1; bcnt = 0; acc = '0;
      end else if (p_scl && !scl_low && in_xfer && bcnt < 27) begin
        if (bcnt > 0) chk_int("R6", "cycles between clock rises", cyc - last_rise, 4*QTR);
        last_rise = cyc;
        if (bcnt % 9 == 8) chk("R5", "ninth bit released", sda_low, 1'b0);
        else acc = {acc[22:0], !sda_low};
        bcnt++;
      end else if (!p_scl && !scl_low && p_sda && !sda_low && in_xfer) begin
        in_xfer = 1'b0;
        chk_int("R3", "bits in write", bcnt, 27);
        want = (frames_q.size() > 0) ? frames_q.pop_front() : 24'hxxxxxx;
        chk_int("R3", "decoded id/index/value", int'(acc), int'(want));
      end
      p_scl = scl_low;
      p_sda = sda_low;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
    repeat (4) step();
    chk("R1", "busy held in reset", busy, 1'b1);
    chk("R1", "clock released in reset", scl_low, 1'b0);
    chk("R1", "data released in reset", sda_low, 1'b0);
    rst_n = 1'b1;
    // request during the power-on list must be ignored (R8)
    step();
    req_valid = 1'b1; req_addr = 8'h99; req_data = 8'h99;
    repeat (3) step();
    req_valid = 1'b0;
    do step(); while (busy);
    chk_int("R2", "list writes before free", n_done, NBOOT);

    // single host write, then an ignored one while busy
    req_valid = 1'b1; req_addr = 8'hA7; req_data = 8'h01;
    step();
    req_valid = 1'b0;
    chk("R7", "busy after accept", busy, 1'b1);
    repeat (2) step();
    req_valid = 1'b1; req_addr = 8'h5E; req_data = 8'h77;
    step();
    req_valid = 1'b0;
    do step(); while (busy);
    chk_int("R8", "writes after ignored request", n_done, NBOOT + 1);
    repeat (5) step();
    chk("R1", "idle clock released", scl_low, 1'b0);
    chk("R1", "idle data released", sda_low, 1'b0);

    // held request: second one taken in the done cycle
    req_valid = 1'b1; req_addr = 8'hC3; req_data = 8'h3C;
    step();
    req_addr = 8'h0F; req_data = 8'hE1;
    do step(); while (!done);
    step();
    req_valid = 1'b0;
    chk("R10", "busy right after done-cycle request", busy, 1'b1);
    do step(); while (busy);
    chk_int("R10", "back-to-back writes", n_done, NBOOT + 3);
    chk_int("R3", "frames left unmatched", frames_q.size(), 0);
    repeat (5) step();
    finish_run();
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL R9 watchdog: got still running exp finished");
    finish_run();
  end
endmodule